// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Gate

This block produces a set of differential CPU clock pairs from one internal source clock and lets an active-low stop request freeze them cleanly. Each pair is a true output and a complement output, both registered, toggling once every `HALF_CYCLES` source cycles while the pairs run. When the synchronized stop request is active, every true output settles high and every complement output settles low, and both stay there until the request is withdrawn.

All changes happen at phase boundaries of a shared half-period timer. A stop never cuts a phase short. If the request arrives while the true output is high, that high phase just continues as the parked level. If it arrives while the true output is low, the low phase runs to its normal end, the true output rises, and it then stays high. On release, the first phase boundary after the synchronized release gives a falling edge of the true output, and normal running resumes from there.

The stop pin is asynchronous to the source clock. It passes through a synchronizer chain before it reaches the gating logic. A synchronous active-high reset returns every pair to its running phase and clears the synchronizer to "not stopped".

Top module: `cpu_clk_stop`

## Requirements
- R1: While the synchronized stop request is active and a pair has reached its parked state, the true output of that pair is 1 and its complement output is 0.
- R2: All `NUM_PAIRS` pairs (default three, indexed 0 to 2) carry identical waveforms at every cycle.
- R3: Out of reset, each complement output is the exact inverse of its true output on every cycle, whether running or parked.
- R4: The stop pin (`stop_n`, 0 = stop requested) passes through a two-stage synchronizer. A level sampled at source-clock edge k is first used by the gating at edge k+2.
- R5: While running, the true output toggles once every `HALF_CYCLES` source cycles. After reset release, its first rise comes at the `HALF_CYCLES`-th rising source edge. Edges are counted from 1 at the first edge with reset low, and the default is 2.
- R6: A stop request that is seen while the true output is low does not shorten the low phase. The true output rises at its normal boundary and then holds high.
- R7: After the synchronized request is withdrawn, the pair restarts at the next phase boundary with a falling edge of the true output.
- R8: While reset is high, each true output is 0 and each complement output is 1 after every clock edge. The synchronizer is cleared to "not stopped".
- R9: The outputs change only at phase boundaries of the shared half-period timer, never between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Internal source clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous stop request, active low |
| clk_t | output | NUM_PAIRS | True clock outputs, parked high when stopped |
| clk_c | output | NUM_PAIRS | Complement clock outputs, parked low when stopped |

## Verification
The bench targets three situations.

- A stop request that lands while the true output is low. A design that gated immediately would leave a shortened low phase, and the true output would not rise at its normal boundary.
- Release of the request. A design that restarted at the wrong moment would either pull the true output low before the boundary or hold it high for an extra phase.
- Single-cycle stop pulses and a reset applied while parked. A design with the wrong synchronizer depth would shift parking by a cycle. A design with a wrong reset would keep the true output high or leave the complement out of step.

// File: rtl/cpu_clk_stop_pkg.sv
package cpu_clk_stop_pkg;

  // one differential output pair
  typedef struct packed {
    logic t;
    logic c;
  } diff_pair_t;

  // width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/stop_synchronizer.sv
module stop_synchronizer #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic stop_req
);

  logic [STAGES-1:0] chain;

  // reset loads "not stopped" (high) into every stage
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], async_n};
  end

  assign stop_req = ~chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age;
      always_ff @(posedge clk) begin
        if (rst)           age <= 2'd0;
        else if (age != 2) age <= age + 2'd1;
      end
      // R4: request seen by gating equals pin level two edges earlier
      assert_sync_depth_R4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (stop_req == !$past(async_n, 2)));
    end
  endgenerate

endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import cpu_clk_stop_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic boundary
);

  localparam int CW = cnt_width(HALF_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign boundary = (cnt == LAST);

  // R5: count never leaves its range
  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/pair_gate.sv
module pair_gate
  import cpu_clk_stop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boundary,
  input  logic       stop_req,
  output diff_pair_t pair
);

  diff_pair_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q.t <= 1'b0;
      q.c <= 1'b1;
    end else if (boundary && !(stop_req && q.t)) begin
      q.t <= ~q.t;
      q.c <= q.t;
    end
  end

  assign pair = q;

  // R3: complement mirrors true output
  assert_inverse_R3: assert property (@(posedge clk) disable iff (rst)
    q.c != q.t);
  // R9: nothing moves between boundaries
  assert_boundary_only_R9: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(q.t));
  // R1: a parked high true output stays high while stopped
  assert_park_high_R1: assert property (@(posedge clk) disable iff (rst)
    (boundary && stop_req && q.t) |=> q.t);
  // R6: a low phase under stop still ends with a rise
  assert_no_short_low_R6: assert property (@(posedge clk) disable iff (rst)
    (boundary && stop_req && !q.t) |=> q.t);
  // R7: release at a boundary with true high gives a fall
  assert_restart_fall_R7: assert property (@(posedge clk) disable iff (rst)
    (boundary && !stop_req && q.t) |=> !q.t);

endmodule

// File: rtl/cpu_clk_stop.sv
module cpu_clk_stop
  import cpu_clk_stop_pkg::*;
#(
  parameter int NUM_PAIRS   = 3,
  parameter int HALF_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 src_clk,
  input  logic                 rst,
  input  logic                 stop_n,
  output logic [NUM_PAIRS-1:0] clk_t,
  output logic [NUM_PAIRS-1:0] clk_c
);

  logic stop_req;
  logic boundary;

  stop_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (src_clk),
    .rst      (rst),
    .async_n  (stop_n),
    .stop_req (stop_req)
  );

  phase_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk      (src_clk),
    .rst      (rst),
    .boundary (boundary)
  );

  generate
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
      diff_pair_t p;
      pair_gate u_gate (
        .clk      (src_clk),
        .rst      (rst),
        .boundary (boundary),
        .stop_req (stop_req),
        .pair     (p)
      );
      assign clk_t[g] = p.t;
      assign clk_c[g] = p.c;
    end
  endgenerate

  // R2: all pairs run in lockstep
  assert_pairs_equal_R2: assert property (@(posedge src_clk) disable iff (rst)
    (clk_t == {NUM_PAIRS{clk_t[0]}}) && (clk_c == {NUM_PAIRS{clk_c[0]}}));

endmodule

// File: tb/tb_cpu_clk_stop.sv
module tb_cpu_clk_stop;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NV = 26;

  // each entry: {stop_n driven before edge i, expected true output after edge i}
  localparam logic [1:0] VEC [NV] = '{
    2'b10, 2'b11, 2'b11, 2'b10, 2'b10,
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b11, 2'b11, 2'b11,
    2'b00, 2'b00, 2'b01, 2'b01,
    2'b11, 2'b11, 2'b10, 2'b10,
    2'b01,
    2'b11, 2'b11, 2'b11, 2'b10
  };

  logic src_clk = 1'b0;
  logic rst = 1'b1;
  logic stop_n = 1'b1;
  logic [NP-1:0] clk_t, clk_c;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  cpu_clk_stop #(.NUM_PAIRS(NP), .HALF_CYCLES(2), .SYNC_STAGES(2)) dut (
    .src_clk (src_clk),
    .rst     (rst),
    .stop_n  (stop_n),
    .clk_t   (clk_t),
    .clk_c   (clk_c)
  );

  always #(CLK_PERIOD/2) src_clk = ~src_clk;

  always @(posedge src_clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung (got %0d cycles, expected < 5000)", cyc);
      summary();
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input logic exp_t);
    logic [NP-1:0] et, ec;
    et = {NP{exp_t}};
    ec = {NP{~exp_t}};
    n_chk = n_chk + 1;
    if (clk_t !== et || clk_c !== ec) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: t=%b c=%b expected t=%b c=%b", req, clk_t, clk_c, et, ec);
    end
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge src_clk);
    check("R8 reset", 1'b0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R6 R7 R9: vector walk, edge i sampled at following negedge
    for (int i = 0; i < NV; i++) begin
      stop_n = VEC[i][1];
      @(negedge src_clk);
      check($sformatf("R1/R2/R3/R4/R5/R6/R7/R9 vec %0d", i), VEC[i][0]);
    end

    // R1: long stop parks all pairs high/low
    stop_n = 1'b0;
    repeat (8) @(negedge src_clk);
    check("R1 parked", 1'b1);

    // R8: reset while parked returns to running phase
    rst = 1'b1;
    @(negedge src_clk);
    check("R8 reset while parked", 1'b0);
    @(negedge src_clk);
    check("R8 reset held", 1'b0);
    rst = 1'b0;
    // R5: first rise at second edge after release; R4: stop then takes hold
    @(negedge src_clk);
    check("R5 edge0 after reset", 1'b0);
    @(negedge src_clk);
    check("R5 first rise", 1'b1);
    @(negedge src_clk);
    check("R4 between boundaries", 1'b1);
    @(negedge src_clk);
    check("R4 synced stop holds high", 1'b1);
    // R7: release, falling edge at next boundary after sync
    stop_n = 1'b1;
    @(negedge src_clk);
    check("R7 not yet synced", 1'b1);
    @(negedge src_clk);
    check("R7 held through sync", 1'b1);
    @(negedge src_clk);
    check("R7 between boundaries", 1'b1);
    @(negedge src_clk);
    check("R7 restart falls", 1'b0);

    summary();
  end

endmodule